// File: doc/BRIEF.md
# Auxiliary Stereo Serial Capture Port (Clock Master)

This block is a receive-only stereo serial port that always drives its own clocks. A reference clock at 256 times the sample rate is divided by four to make the bit clock. The word clock changes level every 32 bit clocks, so one frame is 64 bit clocks long and matches the frame rate of the companion multi-slot capture interface. An external converter or digital audio receiver shifts one left sample and one right sample per frame onto a single data line. The port deserializes them.

Two serial layouts can be selected at run time. In the left-justified layout, the word clock is high while the left sample is shifted in, and the MSB arrives in the first bit period after the word-clock change. In the I2S layout, the word clock is low for the left sample, and the MSB arrives one bit period later. A hardware strap input forces the left-justified layout. The word depth is programmable from 16 to 24 bits. Each captured word is left-aligned in a 24-bit field, and the unused low bits are zero. The stereo pair is presented together with a one-cycle strobe once per frame, ready to fill the two auxiliary slots of the capture frame.

Top module: `aux_serial_master_rx`

## Requirements
- R1: `bclk` is `clk_ref` divided by four with 50% duty. It is low for two reference cycles and high for two.
- R2: `wclk` changes level only together with a falling `bclk` edge, once every 32 bit periods. This gives a frame of 64 bit periods (256 reference cycles).
- R3: With the left-justified layout (`fmt_i2s`=0), `wclk` is 1 during the left half and 0 during the right half. The MSB of each word is the bit in the first bit period of its half.
- R4: With the I2S layout (`fmt_i2s`=1), `wclk` is 0 during the left half and 1 during the right half. The MSB is the bit in the second bit period of its half.
- R5: While `force_lj`=1, the port behaves exactly as in the left-justified layout, whatever the value of `fmt_i2s`.
- R6: `depth_sel` gives the word depth in bits. Values below 16 act as 16, and values above 24 act as 24.
- R7: A captured word holds the first `depth` received bits, MSB first, in bits 23 downward. The lower 24-`depth` bits are zero. Serial bits after the word and before the next half are ignored.
- R8: `sample_valid` is high for exactly one `clk_ref` cycle per frame, after the last bit of the right half is sampled. `left_word` and `right_word` change only in that cycle and then hold.
- R9: Layout and depth are sampled once, at the frame boundary. Changes inside a frame do not affect the frame in progress.
- R10: While `rst_n`=0, the outputs are as follows: `bclk`=0, `wclk`=1, both words zero, `sample_valid`=0. The first frame after reset uses left-justified, 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, 256 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i2s | input | 1 | Layout select: 1 = I2S, 0 = left-justified |
| force_lj | input | 1 | Hardware strap that forces the left-justified layout |
| depth_sel | input | 5 | Word depth in bits, clamped to 16..24 |
| sdin | input | 1 | Serial data from the external source |
| bclk | output | 1 | Generated bit clock |
| wclk | output | 1 | Generated left/right word clock |
| left_word | output | 24 | Last captured left sample, MSB-aligned |
| right_word | output | 24 | Last captured right sample, MSB-aligned |
| sample_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
A wrong bit-position counter shows up within one frame in two ways. The word clock changes at the wrong place against the bench's own count of bit-clock falls, and the frame length is no longer 256 reference cycles. A wrong layout or depth state appears at the next strobe as shifted or unmasked data, or at the next half boundary as an inverted word-clock level. A stale configuration register shows up as a frame that follows the wrong layout either right after a mode switch or after a brief glitch on the inputs in mid-frame.

// File: rtl/aux_serial_master_rx.sv
module aux_serial_master_rx #(
  parameter int WORD_MAX = 24,
  parameter int WORD_MIN = 16,
  parameter int DIV      = 4,
  parameter int HALF     = 32
) (
  input  logic                              clk_ref,
  input  logic                              rst_n,
  input  logic                              fmt_i2s,
  input  logic                              force_lj,
  input  logic [$clog2(WORD_MAX+1)-1:0]     depth_sel,
  input  logic                              sdin,
  output logic                              bclk,
  output logic                              wclk,
  output logic [WORD_MAX-1:0]               left_word,
  output logic [WORD_MAX-1:0]               right_word,
  output logic                              sample_valid
);
  localparam int DW   = $clog2(DIV);
  localparam int FW   = $clog2(2*HALF);
  localparam int PW   = $clog2(HALF);
  localparam int DEPW = $clog2(WORD_MAX+1);
  localparam int IW   = $clog2(WORD_MAX);

  logic [DW-1:0]       div_q;
  logic [FW-1:0]       pos_q;
  logic                cfg_i2s_q;
  logic [DEPW-1:0]     cfg_depth_q;
  logic [WORD_MAX-1:0] acc_q, acc_next, left_hold_q, left_q, right_q;
  logic                valid_q;

  logic            tick_rise, tick_fall, half;
  logic [PW-1:0]   slot, bit_ofs;
  logic [IW-1:0]   wr_idx;
  logic            in_word;
  logic [DEPW-1:0] depth_eff;

  assign tick_rise = (div_q == DW'(DIV/2 - 1));
  assign tick_fall = (div_q == DW'(DIV - 1));
  assign half      = pos_q[FW-1];
  assign slot      = pos_q[PW-1:0];
  assign bit_ofs   = slot - PW'(cfg_i2s_q);
  assign wr_idx    = IW'(WORD_MAX - 1) - IW'(bit_ofs);
  assign in_word   = int'(bit_ofs) < int'(cfg_depth_q);

  assign depth_eff = (depth_sel < DEPW'(WORD_MIN)) ? DEPW'(WORD_MIN) :
                     (depth_sel > DEPW'(WORD_MAX)) ? DEPW'(WORD_MAX) : depth_sel;

  assign bclk         = (div_q >= DW'(DIV/2));
  assign wclk         = cfg_i2s_q ? half : ~half;
  assign left_word    = left_q;
  assign right_word   = right_q;
  assign sample_valid = valid_q;

  always_comb begin
    acc_next = (slot == '0) ? '0 : acc_q;
    if (in_word) acc_next[wr_idx] = sdin;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      div_q       <= '0;
      pos_q       <= '0;
      cfg_i2s_q   <= 1'b0;
      cfg_depth_q <= DEPW'(WORD_MAX);
      acc_q       <= '0;
      left_hold_q <= '0;
      left_q      <= '0;
      right_q     <= '0;
      valid_q     <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      div_q   <= tick_fall ? '0 : div_q + 1'b1;
      if (tick_rise) begin
        acc_q <= acc_next;
        if (slot == PW'(HALF - 1)) begin
          if (!half) begin
            left_hold_q <= acc_next;
          end else begin
            left_q  <= left_hold_q;
            right_q <= acc_next;
            valid_q <= 1'b1;
          end
        end
      end
      if (tick_fall) begin
        pos_q <= pos_q + 1'b1;
        if (&pos_q) begin
          cfg_i2s_q   <= fmt_i2s & ~force_lj;
          cfg_depth_q <= depth_eff;
        end
      end
    end
  end

  p_bclk_high_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(bclk) |=> bclk);
  p_bclk_low_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(bclk) |=> !bclk);
  p_wclk_on_fall_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$stable(wclk) |-> $fell(bclk));
  p_valid_pulse_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    sample_valid |=> !sample_valid);
  p_words_hold_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !sample_valid |-> ($stable(left_word) && $stable(right_word)));
  p_valid_in_high_bclk_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    sample_valid |-> bclk);
  p_lsb_zero_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    sample_valid |-> (WORD_MAX'(right_word << cfg_depth_q) == '0 &&
                      WORD_MAX'(left_word << cfg_depth_q) == '0));
endmodule

// File: tb/test_aux_serial_master_rx.sv
module test_aux_serial_master_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fmt_i2s = 1'b0, force_lj = 1'b0, sdin = 1'b0;
  logic [4:0] depth_sel = 5'd24;
  logic bclk, wclk, sample_valid;
  logic [23:0] left_word, right_word;

  aux_serial_master_rx i_aux_serial_master_rx (
    .clk_ref(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .force_lj(force_lj),
    .depth_sel(depth_sel), .sdin(sdin), .bclk(bclk), .wclk(wclk),
    .left_word(left_word), .right_word(right_word), .sample_valid(sample_valid));

  always #4 clk = ~clk;

  typedef struct { logic [23:0] l; logic [23:0] r; } pair_t;
  typedef struct { bit chk; logic [23:0] l; logic [23:0] r; string req; } exp_t;
  pair_t txq[$];
  exp_t  expq[$];

  int vectors = 0, fails = 0;
  string cur_req = "R3 R7";
  int ticks = 0, last_start = -1, pos = 0;
  bit f_i2s = 0;
  int f_depth = 24;
  pair_t f_pair = '{24'h0, 24'h0};
  bit seen_first = 0;
  logic [23:0] last_l = '0, last_r = '0;

  function automatic int clampd(int d);
    return d < 16 ? 16 : (d > 24 ? 24 : d);
  endfunction
  function automatic logic [23:0] maskw(logic [23:0] w, int d);
    return w & ~((24'h1 << (24 - d)) - 24'h1);
  endfunction
  function automatic logic [23:0] gen(int k);
    return 24'(k * 32'h009E3779 + 32'h0005A5A5);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) ticks++;

  task automatic start_frame();
    exp_t e;
    if (last_start >= 0) check(ticks - last_start == 256, "R1 R2 frame length", ticks - last_start, 256);
    last_start = ticks;
    check(left_word == last_l && right_word == last_r, "R8 hold", {8'h0, left_word}, {8'h0, last_l});
    f_i2s   = fmt_i2s & ~force_lj;
    f_depth = clampd(int'(depth_sel));
    if (txq.size() > 0) begin
      f_pair = txq.pop_front();
      e.chk = 1;
    end else begin
      f_pair = '{24'hC3C3C3, 24'h3C3C3C};
      e.chk = 0;
    end
    e.l = maskw(f_pair.l, f_depth);
    e.r = maskw(f_pair.r, f_depth);
    e.req = cur_req;
    expq.push_back(e);
  endtask

  initial begin
    wait (rst_n);
    forever begin
      int slot, ofs;
      logic [23:0] w;
      @(negedge bclk);
      #1;
      pos = (pos + 1) % 64;
      if (pos == 0) start_frame();
      if (pos == 0) check(wclk == (f_i2s ? 1'b0 : 1'b1), f_i2s ? "R4 wclk left" : "R3 wclk left", wclk, !f_i2s);
      if (pos == 32) check(wclk == (f_i2s ? 1'b1 : 1'b0), f_i2s ? "R4 wclk right" : "R3 wclk right", wclk, f_i2s);
      slot = pos % 32;
      w = (pos >= 32) ? f_pair.r : f_pair.l;
      ofs = slot - (f_i2s ? 1 : 0);
      sdin = (ofs >= 0 && ofs < 24) ? w[23 - ofs] : 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && sample_valid) begin
      last_l = left_word;
      last_r = right_word;
      if (!seen_first) seen_first = 1;
      else if (expq.size() == 0) check(0, "R8 unexpected strobe", 1, 0);
      else begin
        exp_t e;
        e = expq.pop_front();
        if (e.chk) begin
          check(left_word == e.l, {e.req, " left"}, {8'h0, left_word}, {8'h0, e.l});
          check(right_word == e.r, {e.req, " right"}, {8'h0, right_word}, {8'h0, e.r});
        end
      end
    end
  end

  task automatic run_block(bit i2s, bit frc, int d, int n, int base, string req);
    wait (txq.size() == 0);
    @(posedge sample_valid);
    #1;
    fmt_i2s = i2s; force_lj = frc; depth_sel = 5'(d); cur_req = req;
    for (int i = 0; i < n; i++) txq.push_back('{gen(base + 2*i), gen(base + 2*i + 1)});
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(bclk == 0 && wclk == 1 && sample_valid == 0, "R10 reset clocks", {bclk, wclk, sample_valid}, 3'b010);
    check(left_word == 0 && right_word == 0, "R10 reset words", {8'h0, left_word | right_word}, 0);
    txq.push_back('{24'hFFFFFF, 24'h800001});
    txq.push_back('{gen(1), gen(2)});
    txq.push_back('{24'hA5A5A5, 24'h5A5A5A});
    @(negedge clk);
    rst_n = 1'b1;
    run_block(0, 0, 16, 3, 10, "R3 R7 depth16");
    run_block(1, 0, 24, 3, 20, "R4 I2S 24");
    run_block(1, 0, 20, 3, 30, "R4 R7 I2S 20");
    run_block(1, 1, 18, 3, 40, "R5 forced LJ");
    run_block(0, 0, 8, 2, 50, "R6 clamp low");
    run_block(1, 0, 31, 2, 60, "R6 clamp high");
    run_block(0, 0, 24, 3, 70, "R9 glitch");
    repeat (100) @(posedge clk);
    #1;
    fmt_i2s = 1'b1; depth_sel = 5'd16;
    repeat (50) @(posedge clk);
    #1;
    fmt_i2s = 1'b0; depth_sel = 5'd24;
    run_block(1, 0, 24, 2, 80, "R9 switch back");
    wait (txq.size() == 0);
    @(posedge sample_valid);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule